// File: doc/BRIEF.md
# Dual-Loop Phase Comparator with Lock Meter

This block compares, for each of two synthesizer loops, a reference strobe against a divided-feedback strobe. It turns the phase difference into a three-state pump command: source, sink, or neither (high-Z). All activity is timed on the oscillator clock. The strobes are one clock wide and synchronous to that clock. A per-loop polarity input picks which direction of error drives the source leg. When the two strobes coincide, both legs still receive a short balanced pulse, so that small errors are never lost in a dead zone.

Each loop also has a lock meter. It counts how many oscillator cycles the two edges stayed apart. A long error drops the lock flag at once. The flag is raised again only after a run of consecutive short errors. Each loop can be put into power save. In that state its pump is released and its comparator is cleared. On exit, the first completed comparison is kept off the pump, so the oscillator is not pushed by a stale phase relation.

The lock flags of both loops are merged into one indicator. A monitor output shows either this merged indicator or any one of the four raw strobes. A per-loop current-select bit passes through unchanged to the analog pump.

Top module: `dual_pfd_lock`

## Requirements
- R1: While reset is low and in the cycles right after it, no pump leg is driven and every lock flag reads 0.
- R2: With pol_i=1, a reference strobe that leads its feedback strobe drives pump_src_o from the cycle after the reference strobe until the comparison clears, and a lagging reference drives pump_snk_o; pol_i=0 swaps the two legs.
- R3: Reference and feedback strobes in the same cycle give a single-cycle pulse on both pump_src_o and pump_snk_o (anti-dead-zone), in the cycle after the strobes.
- R4: The error width is the number of cycles in which exactly one comparator flag is set. When the width of the comparison in progress reaches UNLOCK_W (default 3), lock_o clears in the next cycle.
- R5: lock_o sets in the cycle after the LOCK_CNT-th consecutive completed comparison (default 3) whose width is at most LOCK_W (default 2). A completed comparison wider than LOCK_W restarts the run.
- R6: While save_i of a loop is 1, both of that loop's pump legs are 0 in the same cycle. Its comparator, width count, run count and lock flag are cleared, and strobes arriving meanwhile have no later effect.
- R7: After save_i falls, and likewise after reset, the pump legs of the loop stay 0 up to and including the cycle in which the first comparison completes.
- R8: The merged lock indicator is 1 exactly when every loop has lock_o=1 or save_i=1.
- R9: mon_o shows the merged lock indicator when mon_en_i=0. When mon_en_i=1, mon_pick_i bit 0 selects the loop and bit 1 selects the source: 0 gives the reference strobe, 1 gives the feedback strobe. So codes 0,1,2,3 show fr_i[0], fr_i[1], fp_i[0] and fp_i[1].
- R10: cur_o equals cur_i in every cycle.
- R11: A strobe that arrives in the cycle in which a comparison completes is kept and starts the next comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fr_i | input | LOOPS | Reference strobes, one per loop |
| fp_i | input | LOOPS | Divided-feedback strobes, one per loop |
| save_i | input | LOOPS | Power save per loop, 1 = saving |
| pol_i | input | LOOPS | Pump polarity per loop |
| cur_i | input | LOOPS | Pump current select per loop |
| mon_en_i | input | 1 | 1 = show a strobe on mon_o |
| mon_pick_i | input | PICK_W | Strobe choice: bit 0 selects the loop, bit 1 selects feedback |
| pump_src_o | output | LOOPS | Pump source leg (drive high) |
| pump_snk_o | output | LOOPS | Pump sink leg (drive low) |
| cur_o | output | LOOPS | Current select passed to the pump |
| lock_o | output | LOOPS | Per-loop lock flag |
| mon_o | output | 1 | Monitor output |

## Verification
The close call is the completion cycle of a comparison. In that one cycle the lock meter scores the finished width, both pump legs carry the balanced pulse, and a new reference strobe may already be arriving to open the next comparison. The bench provokes this by issuing a second reference strobe in exactly that completion cycle, in the middle of a run of short errors. A behavioural model, holding the loop state in plain integers, predicts the pump legs, lock flags and monitor value for every cycle. Any divergence is reported in the cycle where it first appears, so lost strobes and miscounted runs are caught.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;

  // Saturating increment on plain integers; callers cast to their width.
  function automatic int sat_inc(input int value, input int top);
    return (value >= top) ? top : value + 1;
  endfunction

  // Comparator flag next state: held unless cleared, any strobe sets it.
  function automatic logic flag_next(input logic held, input logic clear, input logic strobe);
    return (held & ~clear) | strobe;
  endfunction

  // Leg steering: polarity picks which comparator flag feeds which leg.
  function automatic logic steer(input logic pol, input logic lead_ref, input logic lead_fb);
    return pol ? lead_ref : lead_fb;
  endfunction

  // True when a width count plus the current cycle reaches a limit.
  function automatic logic width_reaches(input int width, input int limit);
    return (width + 1) >= limit;
  endfunction

  // True when a finished width is short enough to count towards lock.
  function automatic logic width_short(input int width, input int limit);
    return width <= limit;
  endfunction

endpackage

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_lock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic save,
  input  logic fr,
  input  logic fp,
  input  logic pol,
  output logic src,
  output logic snk,
  output logic done,
  output logic err,
  output logic mute
);

  logic ref_q;
  logic fb_q;
  logic mute_q;
  logic drive_ok;

  assign done = ref_q & fb_q;
  assign err  = ref_q ^ fb_q;
  assign mute = mute_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      fb_q   <= 1'b0;
      mute_q <= 1'b1;
    end else if (save) begin
      ref_q  <= 1'b0;
      fb_q   <= 1'b0;
      mute_q <= 1'b1;
    end else begin
      ref_q <= flag_next(ref_q, done, fr);
      fb_q  <= flag_next(fb_q, done, fp);
      if (done) begin
        mute_q <= 1'b0;
      end
    end
  end

  assign drive_ok = ~save & ~mute_q;
  assign src      = drive_ok & steer(pol, ref_q, fb_q);
  assign snk      = drive_ok & steer(pol, fb_q, ref_q);

endmodule

// File: rtl/lock_meter.sv
module lock_meter
  import pfd_lock_pkg::*;
#(
  parameter int WID_W    = 4,
  parameter int LOCK_W   = 2,
  parameter int UNLOCK_W = 3,
  parameter int LOCK_CNT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic save,
  input  logic err,
  input  logic done,
  output logic lock,
  output logic unlock_hit
);

  localparam int WID_MAX = (1 << WID_W) - 1;
  localparam int CNT_W   = $clog2(LOCK_CNT + 1);

  logic [WID_W-1:0] wid_q;
  logic [CNT_W-1:0] run_q;
  logic             lock_q;
  logic             short_hit;
  logic [CNT_W-1:0] run_inc;

  assign unlock_hit = err & width_reaches(int'(wid_q), UNLOCK_W);
  assign short_hit  = done & width_short(int'(wid_q), LOCK_W);
  assign run_inc    = CNT_W'(sat_inc(int'(run_q), LOCK_CNT));
  assign lock       = lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wid_q  <= '0;
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (save) begin
      wid_q  <= '0;
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (done) begin
      wid_q <= '0;
      if (short_hit) begin
        run_q <= run_inc;
        if (int'(run_inc) >= LOCK_CNT) begin
          lock_q <= 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end else if (err) begin
      wid_q <= WID_W'(sat_inc(int'(wid_q), WID_MAX));
      if (unlock_hit) begin
        lock_q <= 1'b0;
        run_q  <= '0;
      end
    end
  end

endmodule

// File: rtl/mon_route.sv
module mon_route #(
  parameter int LOOPS  = 2,
  parameter int PICK_W = 2
) (
  input  logic [LOOPS-1:0]  fr,
  input  logic [LOOPS-1:0]  fp,
  input  logic              lock_all,
  input  logic              en,
  input  logic [PICK_W-1:0] pick,
  output logic              mon
);

  logic [PICK_W-2:0] idx;
  logic              use_fb;

  assign idx    = pick[PICK_W-2:0];
  assign use_fb = pick[PICK_W-1];

  always_comb begin
    if (!en) begin
      mon = lock_all;
    end else if (use_fb) begin
      mon = fp[idx];
    end else begin
      mon = fr[idx];
    end
  end

endmodule

// File: rtl/dual_pfd_lock.sv
module dual_pfd_lock #(
  parameter int LOOPS    = 2,
  parameter int WID_W    = 4,
  parameter int LOCK_W   = 2,
  parameter int UNLOCK_W = 3,
  parameter int LOCK_CNT = 3,
  localparam int PICK_W  = $clog2(LOOPS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOOPS-1:0]  fr_i,
  input  logic [LOOPS-1:0]  fp_i,
  input  logic [LOOPS-1:0]  save_i,
  input  logic [LOOPS-1:0]  pol_i,
  input  logic [LOOPS-1:0]  cur_i,
  input  logic              mon_en_i,
  input  logic [PICK_W-1:0] mon_pick_i,
  output logic [LOOPS-1:0]  pump_src_o,
  output logic [LOOPS-1:0]  pump_snk_o,
  output logic [LOOPS-1:0]  cur_o,
  output logic [LOOPS-1:0]  lock_o,
  output logic              mon_o
);

  // Internal events brought out for the checker.
  logic [LOOPS-1:0] done_w;
  logic [LOOPS-1:0] err_w;
  logic [LOOPS-1:0] mute_w;
  logic [LOOPS-1:0] unlock_w;
  logic             lock_all_w;

  for (genvar g = 0; g < LOOPS; g++) begin : g_loop
    pfd_core u_core (
      .clk  (clk),
      .rst_n(rst_n),
      .save (save_i[g]),
      .fr   (fr_i[g]),
      .fp   (fp_i[g]),
      .pol  (pol_i[g]),
      .src  (pump_src_o[g]),
      .snk  (pump_snk_o[g]),
      .done (done_w[g]),
      .err  (err_w[g]),
      .mute (mute_w[g])
    );

    lock_meter #(
      .WID_W   (WID_W),
      .LOCK_W  (LOCK_W),
      .UNLOCK_W(UNLOCK_W),
      .LOCK_CNT(LOCK_CNT)
    ) u_meter (
      .clk       (clk),
      .rst_n     (rst_n),
      .save      (save_i[g]),
      .err       (err_w[g]),
      .done      (done_w[g]),
      .lock      (lock_o[g]),
      .unlock_hit(unlock_w[g])
    );
  end

  assign lock_all_w = &(lock_o | save_i);
  assign cur_o      = cur_i;

  mon_route #(
    .LOOPS (LOOPS),
    .PICK_W(PICK_W)
  ) u_mon (
    .fr      (fr_i),
    .fp      (fp_i),
    .lock_all(lock_all_w),
    .en      (mon_en_i),
    .pick    (mon_pick_i),
    .mon     (mon_o)
  );

endmodule

// File: rtl/dual_pfd_lock_chk.sv
module dual_pfd_lock_chk #(
  parameter int LOOPS = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LOOPS-1:0] save,
  input logic [LOOPS-1:0] src,
  input logic [LOOPS-1:0] snk,
  input logic [LOOPS-1:0] lock,
  input logic [LOOPS-1:0] done,
  input logic [LOOPS-1:0] mute,
  input logic [LOOPS-1:0] unlock_hit,
  input logic             lock_all
);

  for (genvar g = 0; g < LOOPS; g++) begin : g_chk
    p_quiet_save_r6: assert property (@(posedge clk) disable iff (!rst_n)
      save[g] |-> (!src[g] && !snk[g]));

    p_exit_muted_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(save[g]) |-> (mute[g] && !src[g] && !snk[g]));

    p_pair_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (src[g] && snk[g]) |-> done[g]);

    p_lock_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock[g]) |-> $past(done[g]));

    p_lock_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock[g]) |-> ($past(save[g]) || $past(unlock_hit[g])));

    p_drop_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
      unlock_hit[g] |=> !lock[g]);

    p_merged_r8: assert property (@(posedge clk) disable iff (!rst_n)
      lock_all |-> (lock[g] || save[g]));
  end

endmodule

bind dual_pfd_lock dual_pfd_lock_chk #(.LOOPS(LOOPS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .save      (save_i),
  .src       (pump_src_o),
  .snk       (pump_snk_o),
  .lock      (lock_o),
  .done      (done_w),
  .mute      (mute_w),
  .unlock_hit(unlock_w),
  .lock_all  (lock_all_w)
);

// File: tb/tb_dual_pfd_lock.sv
module tb_dual_pfd_lock;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] fr_i = '0, fp_i = '0, save_i = '0, pol_i = 2'b11, cur_i = '0;
  logic       mon_en_i = 1'b0;
  logic [1:0] mon_pick_i = '0;
  logic [1:0] pump_src_o, pump_snk_o, cur_o, lock_o;
  logic       mon_o;

  int    vectors = 0;
  int    misses  = 0;
  string tag     = "R1";

  // Behavioural model state, one entry per loop.
  int m_ref[2], m_fb[2], m_w[2], m_run[2], m_lock[2], m_mute[2];

  dual_pfd_lock dut (
    .clk(clk), .rst_n(rst_n), .fr_i(fr_i), .fp_i(fp_i), .save_i(save_i),
    .pol_i(pol_i), .cur_i(cur_i), .mon_en_i(mon_en_i), .mon_pick_i(mon_pick_i),
    .pump_src_o(pump_src_o), .pump_snk_o(pump_snk_o), .cur_o(cur_o),
    .lock_o(lock_o), .mon_o(mon_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Model update at each rising edge from the inputs held since the last edge.
  always @(posedge clk or negedge rst_n) begin
    for (int l = 0; l < 2; l++) begin
      if (!rst_n || save_i[l]) begin
        m_ref[l] = 0; m_fb[l] = 0; m_w[l] = 0; m_run[l] = 0; m_lock[l] = 0; m_mute[l] = 1;
      end else begin
        bit both, one;
        both = (m_ref[l] == 1) && (m_fb[l] == 1);
        one  = (m_ref[l] != m_fb[l]);
        if (both) begin
          if (m_w[l] <= 2) begin
            m_run[l] = (m_run[l] < 3) ? m_run[l] + 1 : 3;
            if (m_run[l] == 3) m_lock[l] = 1;
          end else m_run[l] = 0;
          m_w[l] = 0;
          m_mute[l] = 0;
          m_ref[l] = fr_i[l];
          m_fb[l]  = fp_i[l];
        end else begin
          if (one) begin
            if (m_w[l] + 1 >= 3) begin m_lock[l] = 0; m_run[l] = 0; end
            m_w[l] = (m_w[l] < 15) ? m_w[l] + 1 : 15;
          end
          if (fr_i[l]) m_ref[l] = 1;
          if (fp_i[l]) m_fb[l] = 1;
        end
      end
    end
  end

  task automatic cmp(input string what, input int act, input int exp);
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare every output away from the rising edge.
  always @(negedge clk) begin
    int merged, e_mon, drive, up, dn;
    vectors++;
    merged = 1;
    for (int l = 0; l < 2; l++) begin
      if (!(m_lock[l] == 1 || save_i[l])) merged = 0;
      drive = (!save_i[l] && m_mute[l] == 0) ? 1 : 0;
      up = pol_i[l] ? m_ref[l] : m_fb[l];
      dn = pol_i[l] ? m_fb[l] : m_ref[l];
      cmp($sformatf("src[%0d]", l), pump_src_o[l], drive & up);
      cmp($sformatf("snk[%0d]", l), pump_snk_o[l], drive & dn);
      cmp($sformatf("lock[%0d]", l), lock_o[l], m_lock[l]);
      cmp($sformatf("cur[%0d] R10", l), cur_o[l], cur_i[l]);
    end
    if (!mon_en_i) e_mon = merged;
    else if (mon_pick_i[1]) e_mon = fp_i[mon_pick_i[0]];
    else e_mon = fr_i[mon_pick_i[0]];
    cmp("mon R9/R8", mon_o, e_mon);
  end

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // One comparison on loop l: k>0 reference leads by k, k<0 feedback leads.
  task automatic pair(input int l, input int k, input int gap);
    if (k == 0) begin
      fr_i[l] = 1; fp_i[l] = 1; step(); fr_i[l] = 0; fp_i[l] = 0;
    end else begin
      if (k > 0) fr_i[l] = 1; else fp_i[l] = 1;
      step(); fr_i[l] = 0; fp_i[l] = 0;
      step(((k > 0) ? k : -k) - 1);
      if (k > 0) fp_i[l] = 1; else fr_i[l] = 1;
      step(); fr_i[l] = 0; fp_i[l] = 0;
    end
    step(gap);
  endtask

  task automatic expect_lock(input int l, input int v);
    @(negedge clk);
    cmp($sformatf("lock[%0d] directed", l), lock_o[l], v);
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired R1 act=0 exp=1");
    finish_run();
  end

  initial begin
    tag = "R1"; step(3); rst_n = 1; step(3);
    expect_lock(0, 0);
    tag = "R7"; pair(0, 2, 4); pair(1, -2, 4);      // first comparisons muted
    tag = "R2"; pair(0, 2, 4); pair(0, -2, 4);
    pol_i[0] = 0; pair(0, 2, 4); pair(0, -3, 4); pol_i[0] = 1;
    tag = "R3"; pair(0, 0, 4); pair(1, 0, 4);
    tag = "R5"; pair(0, 1, 3); pair(0, 2, 3); pair(0, 0, 3);
    expect_lock(0, 1);
    pair(0, 2, 3); expect_lock(0, 1);
    tag = "R4"; pair(0, 3, 3); expect_lock(0, 0);
    tag = "R5"; pair(0, 1, 3); pair(0, 1, 3); pair(0, 4, 3); pair(0, 1, 3);
    expect_lock(0, 0);
    pair(0, 1, 3); pair(0, 0, 3); expect_lock(0, 1);
    tag = "R4"; pair(0, -6, 3); expect_lock(0, 0);
    tag = "R11";
    fr_i[0] = 1; step(); fr_i[0] = 0; fp_i[0] = 1; step(); fp_i[0] = 0;
    fr_i[0] = 1; step(); fr_i[0] = 0; fp_i[0] = 1; step(); fp_i[0] = 0; step(3);
    pair(0, 1, 3); expect_lock(0, 1);
    tag = "R6"; save_i[0] = 1; step(); pair(0, 2, 2); pair(0, 0, 2);
    expect_lock(0, 0);
    tag = "R8"; pair(1, 1, 3); pair(1, 1, 3); pair(1, 1, 3); step(2);
    save_i[0] = 0;
    tag = "R7"; step(); pair(0, 3, 3); pair(0, -2, 3);
    tag = "R8"; pair(0, 1, 3); pair(0, 1, 3); pair(0, 1, 3);
    expect_lock(1, 1);
    save_i[1] = 1; step(3); pair(1, 2, 3); save_i[1] = 0; step(2);
    pair(0, 5, 3); save_i[0] = 1; step(3); save_i[1] = 1; step(2);
    save_i = 2'b00; step(2);
    tag = "R9"; mon_en_i = 1;
    for (int p = 0; p < 4; p++) begin
      mon_pick_i = 2'(p);
      pair(0, 1, 2); pair(1, -2, 2); pair(0, 0, 2);
    end
    mon_en_i = 0; step(2);
    tag = "R10";
    for (int c = 0; c < 4; c++) begin cur_i = 2'(c); step(2); end
    step(4);
    finish_run();
  end

endmodule